// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block performs one logical block write on a five-column disk array that keeps one XOR parity unit per stripe. The parity column moves one column to the left on each successive stripe, so the parity load is spread over all columns. The host presents a logical block number and a new data word. The engine converts that single logical write into four physical column operations. First it fetches the old contents of the target data unit and of the stripe's parity unit. It then folds both with the new word into a fresh parity value. Finally it writes the new data and then the new parity.

The host side is a valid/ready request. The engine accepts one request at a time and signals completion with a single-cycle pulse. The disk side is a column-addressed port. The engine holds a request with its column, row, direction and write word until the disk returns a one-cycle acknowledge. For reads, the returned word is valid in the acknowledge cycle.

Top module: `parity_rmw_top`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `dsk_req` is 0.
- R2: Every physical operation of a logical write to block L addresses row L/4 (integer division), the stripe number.
- R3: The parity unit of stripe S lives in column 4 - (S mod 5). Stripe 0 uses column 4, stripe 4 uses column 0, and stripe 5 uses column 4 again.
- R4: Data position L mod 4 maps onto the non-parity columns in ascending order. A position below the parity column uses the column equal to the position. Any other position uses the position plus one.
- R5: The four operations run in a fixed order, and the first is issued in the cycle after acceptance. The order is: read data column (`dsk_we`=0), read parity column (`dsk_we`=0), write data column (`dsk_we`=1), write parity column (`dsk_we`=1).
- R6: The parity write carries old parity XOR old data XOR new data. The old values are the words returned on `dsk_rdata` with the two read acknowledges.
- R7: The data write carries the word presented on `req_data` at acceptance.
- R8: `req_ready` is low from the cycle after acceptance until the parity write is acknowledged. While the engine is busy, `req_valid` and its payload have no effect: no further operations follow completion.
- R9: `done` is high for exactly one cycle, in the cycle after the parity write acknowledge. `req_ready` returns high in that same cycle.
- R10: While `dsk_req` is high and unacknowledged, column, row, direction and write word stay stable. A `dsk_ack` while no request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_lbn | input | LBN_W | Logical block number |
| req_data | input | DATA_W | New data word |
| done | output | 1 | One-cycle completion pulse |
| dsk_req | output | 1 | Disk operation pending |
| dsk_we | output | 1 | 1 = write, 0 = read |
| dsk_col | output | 3 | Target column 0..4 |
| dsk_row | output | LBN_W-2 | Row (stripe) address |
| dsk_wdata | output | DATA_W | Write word |
| dsk_rdata | input | DATA_W | Read word, valid with acknowledge |
| dsk_ack | input | 1 | One-cycle operation acknowledge |

## Verification
The bench walks logical blocks 0 to 23 and beyond, so that parity occupies every column and wraps back at stripe 5. A mapper that rotated the wrong way, or that failed to skip the parity column, would address the wrong column. It drives reads with distinct per-location words under varying acknowledge latency. A parity fold that dropped one operand, or that latched the read word in the wrong cycle, would then write a wrong parity word. It also holds a second request valid throughout a busy write and pulses a stray acknowledge while idle. An engine that accepted work early or reacted to unsolicited acknowledges would issue extra disk operations.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int NUM_COLS = 5;
    localparam int COL_W    = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_DATA,
        PH_RD_PAR,
        PH_WR_DATA,
        PH_WR_PAR
    } phase_e;
endpackage

// File: rtl/stripe_map.sv
module stripe_map
    import rmw_pkg::*;
#(
    parameter int LBN_W = 16,
    localparam int ROW_W = LBN_W - 2
) (
    input  logic [LBN_W-1:0] lbn,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] data_col,
    output logic [COL_W-1:0] par_col
);
    logic [ROW_W-1:0] rot_full;
    logic [COL_W-1:0] pos;

    always_comb begin
        row      = lbn[LBN_W-1:2];
        rot_full = row % ROW_W'(NUM_COLS);
        par_col  = COL_W'(NUM_COLS - 1) - rot_full[COL_W-1:0];
        pos      = {1'b0, lbn[1:0]};
        if (pos < par_col) data_col = pos;
        else               data_col = pos + COL_W'(1);
    end
endmodule

// File: rtl/parity_fold.sv
module parity_fold #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W
) (
    input  logic [DATA_W-1:0] old_par,
    input  logic [DATA_W-1:0] old_data,
    input  logic [DATA_W-1:0] new_data,
    output logic [DATA_W-1:0] new_par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = ((g + 1) * LANE_W > DATA_W) ? DATA_W - 1 : (g + 1) * LANE_W - 1;
        assign new_par[HI:LO] = old_par[HI:LO] ^ old_data[HI:LO] ^ new_data[HI:LO];
    end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  map_row,
    input  logic [COL_W-1:0]  map_dcol,
    input  logic [COL_W-1:0]  map_pcol,
    input  logic [DATA_W-1:0] start_data,
    input  logic [DATA_W-1:0] folded_par,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              ack,
    output logic              idle,
    output logic              done,
    output logic              op_req,
    output logic              op_we,
    output logic [COL_W-1:0]  op_col,
    output logic [ROW_W-1:0]  op_row,
    output logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] held_old,
    output logic [DATA_W-1:0] held_new
);
    typedef struct packed {
        phase_e            ph;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  dcol;
        logic [COL_W-1:0]  pcol;
        logic [DATA_W-1:0] new_w;
        logic [DATA_W-1:0] old_w;
        logic [DATA_W-1:0] par_w;
        logic              fin;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph    = PH_RD_DATA;
                    s_d.row   = map_row;
                    s_d.dcol  = map_dcol;
                    s_d.pcol  = map_pcol;
                    s_d.new_w = start_data;
                end
            end
            PH_RD_DATA: begin
                if (ack) begin
                    s_d.old_w = rd_word;
                    s_d.ph    = PH_RD_PAR;
                end
            end
            PH_RD_PAR: begin
                if (ack) begin
                    s_d.par_w = folded_par;
                    s_d.ph    = PH_WR_DATA;
                end
            end
            PH_WR_DATA: begin
                if (ack) s_d.ph = PH_WR_PAR;
            end
            PH_WR_PAR: begin
                if (ack) begin
                    s_d.ph  = PH_IDLE;
                    s_d.fin = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        idle     = (s_q.ph == PH_IDLE);
        done     = s_q.fin;
        op_req   = !idle;
        op_we    = (s_q.ph == PH_WR_DATA) || (s_q.ph == PH_WR_PAR);
        op_col   = ((s_q.ph == PH_RD_PAR) || (s_q.ph == PH_WR_PAR)) ? s_q.pcol : s_q.dcol;
        op_row   = s_q.row;
        op_wdata = (s_q.ph == PH_WR_PAR) ? s_q.par_w : s_q.new_w;
        held_old = s_q.old_w;
        held_new = s_q.new_w;
    end
endmodule

// File: rtl/parity_rmw_top.sv
module parity_rmw_top
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LBN_W  = 16,
    localparam int ROW_W = LBN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LBN_W-1:0]  req_lbn,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              dsk_req,
    output logic              dsk_we,
    output logic [COL_W-1:0]  dsk_col,
    output logic [ROW_W-1:0]  dsk_row,
    output logic [DATA_W-1:0] dsk_wdata,
    input  logic [DATA_W-1:0] dsk_rdata,
    input  logic              dsk_ack
);
    logic [ROW_W-1:0]  m_row;
    logic [COL_W-1:0]  m_dcol;
    logic [COL_W-1:0]  m_pcol;
    logic [DATA_W-1:0] f_par;
    logic [DATA_W-1:0] h_old;
    logic [DATA_W-1:0] h_new;
    logic              is_idle;

    stripe_map #(.LBN_W(LBN_W)) u_map (
        .lbn      (req_lbn),
        .row      (m_row),
        .data_col (m_dcol),
        .par_col  (m_pcol)
    );

    parity_fold #(.DATA_W(DATA_W)) u_fold (
        .old_par  (dsk_rdata),
        .old_data (h_old),
        .new_data (h_new),
        .new_par  (f_par)
    );

    rmw_seq #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_valid && is_idle),
        .map_row    (m_row),
        .map_dcol   (m_dcol),
        .map_pcol   (m_pcol),
        .start_data (req_data),
        .folded_par (f_par),
        .rd_word    (dsk_rdata),
        .ack        (dsk_ack),
        .idle       (is_idle),
        .done       (done),
        .op_req     (dsk_req),
        .op_we      (dsk_we),
        .op_col     (dsk_col),
        .op_row     (dsk_row),
        .op_wdata   (dsk_wdata),
        .held_old   (h_old),
        .held_new   (h_new)
    );

    assign req_ready = is_idle;
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              dsk_req,
    input logic              dsk_we,
    input logic [2:0]        dsk_col,
    input logic [ROW_W-1:0]  dsk_row,
    input logic [DATA_W-1:0] dsk_wdata,
    input logic              dsk_ack
);
    assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_req |-> (dsk_col < 3'd5));

    assert_first_is_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (dsk_req && !dsk_we));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !dsk_req);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !dsk_req));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_req && !dsk_ack) |=> (dsk_req && $stable(dsk_col) && $stable(dsk_row)
                                    && $stable(dsk_we) && $stable(dsk_wdata)));

    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid && dsk_ack) |=> (req_ready && !dsk_req));
endmodule

bind parity_rmw_top rmw_checker #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .dsk_req   (dsk_req),
    .dsk_we    (dsk_we),
    .dsk_col   (dsk_col),
    .dsk_row   (dsk_row),
    .dsk_wdata (dsk_wdata),
    .dsk_ack   (dsk_ack)
);

// File: tb/sim_parity_rmw_top.sv
module sim_parity_rmw_top;
    localparam int DW = 32;
    localparam int LW = 16;
    localparam int RW = LW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [LW-1:0] req_lbn = '0;
    logic [DW-1:0] req_data = '0;
    logic          done;
    logic          dsk_req;
    logic          dsk_we;
    logic [2:0]    dsk_col;
    logic [RW-1:0] dsk_row;
    logic [DW-1:0] dsk_wdata;
    logic [DW-1:0] dsk_rdata = '0;
    logic          dsk_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] mem [5][64];

    always #10 clk = ~clk;

    parity_rmw_top #(.DATA_W(DW), .LBN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lbn(req_lbn), .req_data(req_data), .done(done), .dsk_req(dsk_req),
        .dsk_we(dsk_we), .dsk_col(dsk_col), .dsk_row(dsk_row), .dsk_wdata(dsk_wdata),
        .dsk_rdata(dsk_rdata), .dsk_ack(dsk_ack)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int ref_pcol(int lbn);
        return 4 - ((lbn / 4) % 5);
    endfunction

    function automatic int ref_dcol(int lbn);
        int pos = lbn % 4;
        return (pos < ref_pcol(lbn)) ? pos : pos + 1;
    endfunction

    // One logical write with a behavioural disk; busy_poke keeps a second request valid while busy
    task automatic do_write(int lbn, logic [DW-1:0] nd, int lat, bit busy_poke);
        int row = lbn / 4;
        int dc = ref_dcol(lbn);
        int pc = ref_pcol(lbn);
        logic [DW-1:0] od = mem[dc][row];
        logic [DW-1:0] op = mem[pc][row];
        @(negedge clk);
        chk("R8 ready before accept", req_ready, 1);
        req_valid = 1'b1;
        req_lbn   = LW'(lbn);
        req_data  = nd;
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < lat; c++) begin
                @(negedge clk);
                dsk_ack = 1'b0;
                if (busy_poke) begin
                    req_lbn  = LW'(lbn + 7);
                    req_data = ~nd;
                end else begin
                    req_valid = 1'b0;
                end
                chk("R5 req pending", dsk_req, 1);
                chk("R5 direction", dsk_we, (k >= 2) ? 1 : 0);
                chk("R2 row", dsk_row, row);
                if (k == 0 || k == 2) chk("R4 data column", dsk_col, dc);
                else                  chk("R3 parity column", dsk_col, pc);
                if (k == 2) chk("R7 data write word", dsk_wdata, nd);
                if (k == 3) chk("R6 parity write word", dsk_wdata, op ^ od ^ nd);
                chk("R8 ready low busy", req_ready, 0);
                chk("R9 no early done", done, 0);
                if (c == lat - 1) begin
                    dsk_ack = 1'b1;
                    if (k == 0) dsk_rdata = od;
                    else if (k == 1) dsk_rdata = op;
                    else dsk_rdata = 32'hDEAD_0000 + DW'(k);
                    if (k == 2) mem[dc][row] = nd;
                    if (k == 3) begin
                        mem[pc][row] = op ^ od ^ nd;
                        req_valid = 1'b0;
                    end
                end
            end
        end
        @(negedge clk);
        dsk_ack = 1'b0;
        chk("R9 done pulse", done, 1);
        chk("R9 ready with done", req_ready, 1);
        chk("R8 no further op", dsk_req, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R8 busy request ignored", dsk_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        for (int c = 0; c < 5; c++)
            for (int r = 0; r < 64; r++)
                mem[c][r] = 32'hA500_0000 ^ (DW'(c) << 16) ^ (DW'(r) * 32'h0101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 req after reset", dsk_req, 0);

        // R10: stray acknowledge while idle
        dsk_ack = 1'b1;
        @(negedge clk);
        dsk_ack = 1'b0;
        chk("R10 stray ack req", dsk_req, 0);
        chk("R10 stray ack ready", req_ready, 1);
        @(negedge clk);
        chk("R10 stray ack done", done, 0);

        // every stripe position through two rotation periods
        for (int l = 0; l < 44; l++)
            do_write(l, 32'h1234_0000 ^ (DW'(l) * 32'h0003_1F07), 1 + (l % 3), 1'b0);
        // high blocks, repeated block, busy request held valid
        do_write(255, 32'hFFFF_0001, 2, 1'b0);
        do_write(4, 32'h0BAD_F00D, 1, 1'b1);
        do_write(4, 32'h600D_CAFE, 4, 1'b1);
        do_write(17, 32'h0000_0000, 3, 1'b0);
        report();
    end
endmodule